// File: doc/BRIEF.md
# Four-Group Look-Ahead Carry Generator

This block computes, in a single combinational pass, the carries that enter the second, third and fourth of four adder slices (or four groups of slices). It takes each slice's generate and propagate flags and the carry that enters the first slice. It also produces a group generate and a group propagate for the whole four-slice span. These two outputs feed a higher-level instance of the same block, so look-ahead trees of any depth can be built from it.

The generate and propagate signals use active-low polarity on every port: the inputs from the slices and the two group outputs. The carry input and the three carry outputs use active-high polarity. Slices that use the same convention therefore connect to the block directly, with no inverters in between.

The block has no clock, no reset and no parameters on its interface. Every output depends only on the present inputs. The block does not produce the carry out of the fourth slice. The next level up forms that carry from the group generate and group propagate outputs.

Top module: `lac_gen4`

## Requirements
- R1: Bit k of `gen_n_i` and bit k of `prop_n_i` mean "slice k generates" and "slice k propagates" when the bit is 0. A value of 1 means the flag is not asserted. Slice 0 is the least significant slice.
- R2: `carry_x_o` is 1 exactly when slice 0 generates, or when slice 0 propagates and `carry_i` is 1.
- R3: `carry_y_o` is 1 exactly when slice 1 generates, or slice 1 propagates and `carry_x_o` would be 1. This is computed by look-ahead, not by a chain through `carry_x_o`.
- R4: `carry_z_o` is 1 exactly when slice 2 generates, or slice 2 propagates and the carry into slice 2 (the R3 value) is 1.
- R5: `grp_gen_n_o` is 0 exactly when a carry leaves slice 3 with `carry_i` held at 0. It has the same value for both values of `carry_i`.
- R6: `grp_prop_n_o` is 0 exactly when all four bits of `prop_n_i` are 0.
- R7: The outputs hold no state. Each of the 512 input combinations gives the same outputs whatever combination was applied before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gen_n_i | input | 4 | Per-slice generate flags, active-low; bit 0 is the least significant slice |
| prop_n_i | input | 4 | Per-slice propagate flags, active-low |
| carry_i | input | 1 | Carry into slice 0, active-high |
| carry_x_o | output | 1 | Carry into slice 1, active-high |
| carry_y_o | output | 1 | Carry into slice 2, active-high |
| carry_z_o | output | 1 | Carry into slice 3, active-high |
| grp_gen_n_o | output | 1 | Group generate over all four slices, active-low |
| grp_prop_n_o | output | 1 | Group propagate over all four slices, active-low |

## Verification
The assertions assume that every input is a driven 0 or 1 and that they are evaluated only after the combinational inputs have settled. An X or Z on any input would make these implications meaningless. The stimulus applies every one of the 512 input combinations as clean binary values. It changes them only at one clock edge, and the outputs are compared half a period later. It sweeps the combinations once in ascending order and once in descending order, so each combination follows a different neighbour each time. A correct result therefore cannot depend on the combination applied before it.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // number of slices one generator looks across
  localparam int unsigned LAC_GROUPS = 4;
  // number of intermediate carries produced (no carry out of the last slice)
  localparam int unsigned LAC_CARRIES = LAC_GROUPS - 1;
endpackage

// File: rtl/lac_pol_flip.sv
// Polarity conversion between active-low port signalling and true-sense logic.
module lac_pol_flip #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] sig_o
);
  assign sig_o = ~sig_i;
endmodule

// File: rtl/lac_sop_row.sv
// One look-ahead term: OR of each generate ANDed with every propagate above it,
// plus the full propagate product ANDed with the incoming carry.
module lac_sop_row #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] gen_t_i,
  input  logic [WIDTH-1:0] prop_t_i,
  input  logic             cin_i,
  output logic             cout_o
);
  logic [WIDTH:0] term;

  // term[k] : generate at k survives all propagates above k
  // term[WIDTH] : incoming carry survives every propagate
  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      term[k] = gen_t_i[k];
      for (int m = k + 1; m < WIDTH; m++) begin
        term[k] = term[k] & prop_t_i[m];
      end
    end
    term[WIDTH] = cin_i & (&prop_t_i);
  end

  assign cout_o = |term;
endmodule

// File: rtl/lac_gen4.sv
module lac_gen4
  import lac_pkg::*;
(
  input  logic [3:0] gen_n_i,
  input  logic [3:0] prop_n_i,
  input  logic       carry_i,
  output logic       carry_x_o,
  output logic       carry_y_o,
  output logic       carry_z_o,
  output logic       grp_gen_n_o,
  output logic       grp_prop_n_o
);
  logic [LAC_GROUPS-1:0]  gen_t;
  logic [LAC_GROUPS-1:0]  prop_t;
  logic [LAC_CARRIES-1:0] carry_t;
  logic [1:0]             grp_t;
  logic [1:0]             grp_n;

  lac_pol_flip #(.WIDTH(LAC_GROUPS)) u_gen_flip  (.sig_i(gen_n_i),  .sig_o(gen_t));
  lac_pol_flip #(.WIDTH(LAC_GROUPS)) u_prop_flip (.sig_i(prop_n_i), .sig_o(prop_t));

  // carry into slice i+1, flat two-level form per output
  for (genvar i = 0; i < LAC_CARRIES; i++) begin : g_carry
    lac_sop_row #(.WIDTH(i + 1)) u_row (
      .gen_t_i (gen_t[i:0]),
      .prop_t_i(prop_t[i:0]),
      .cin_i   (carry_i),
      .cout_o  (carry_t[i])
    );
  end

  // group generate: same form over all slices, incoming carry excluded
  lac_sop_row #(.WIDTH(LAC_GROUPS)) u_grp_gen (
    .gen_t_i (gen_t),
    .prop_t_i(prop_t),
    .cin_i   (1'b0),
    .cout_o  (grp_t[0])
  );

  assign grp_t[1] = &prop_t;

  lac_pol_flip #(.WIDTH(2)) u_grp_flip (.sig_i(grp_t), .sig_o(grp_n));

  assign carry_x_o    = carry_t[0];
  assign carry_y_o    = carry_t[1];
  assign carry_z_o    = carry_t[2];
  assign grp_gen_n_o  = grp_n[0];
  assign grp_prop_n_o = grp_n[1];
endmodule

// File: rtl/lac_gen4_chk.sv
module lac_gen4_chk (
  input logic [3:0] gen_n_i,
  input logic [3:0] prop_n_i,
  input logic       carry_i,
  input logic       carry_x_o,
  input logic       carry_y_o,
  input logic       carry_z_o,
  input logic       grp_gen_n_o,
  input logic       grp_prop_n_o
);
  always_comb begin
    // R2
    slice0_gen_chk: assert (gen_n_i[0] || carry_x_o);
    // R1
    full_prop_chk: assert (!(prop_n_i == 4'b0000 && carry_i) ||
                           (carry_x_o && carry_y_o && carry_z_o));
    // R4
    no_source_chk: assert (!(gen_n_i == 4'b1111 && !carry_i) ||
                           (!carry_x_o && !carry_y_o && !carry_z_o && grp_gen_n_o));
    // R5
    top_gen_chk: assert (gen_n_i[3] || !grp_gen_n_o);
    // R6
    prop_block_chk: assert (!(grp_prop_n_o == 1'b0) || (carry_i == carry_x_o) || !gen_n_i[0]);
    // R3
    slice1_kill_chk: assert (!(gen_n_i[1] && prop_n_i[1]) || !carry_y_o);
  end
endmodule

bind lac_gen4 lac_gen4_chk u_chk (.*);

// File: tb/lac_gen4_bench.sv
module lac_gen4_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic [8:0] stim;
    logic [4:0] exp; // {grp_prop_n, grp_gen_n, z, y, x}
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] gen_n, prop_n;
  logic       cin;
  logic       cx, cy, cz, ggn, gpn;
  item_t      sb_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         drive_done = 0;
  bit         mon_done = 0;

  lac_gen4 u_lac_gen4 (
    .gen_n_i(gen_n), .prop_n_i(prop_n), .carry_i(cin),
    .carry_x_o(cx), .carry_y_o(cy), .carry_z_o(cz),
    .grp_gen_n_o(ggn), .grp_prop_n_o(gpn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference: ripple accumulation in true sense
  function automatic logic [4:0] model(input logic [8:0] s);
    logic [3:0] g, p;
    logic c, gg;
    logic [2:0] cs;
    g = ~s[3:0]; p = ~s[7:4]; c = s[8];
    for (int k = 0; k < 3; k++) begin
      c = g[k] | (p[k] & c);
      cs[k] = c;
    end
    gg = 1'b0;
    for (int k = 0; k < 4; k++) gg = g[k] | (p[k] & gg);
    return {~(&p), ~gg, cs};
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stim=%0d actual=%b expected=%b", req, idx, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] s);
    item_t it;
    @(posedge clk);
    {cin, prop_n, gen_n} = s;
    it.stim = s;
    it.exp  = model(s);
    sb_q.push_back(it);
  endtask

  // monitor: compares half a period after each drive
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check("R2", cx,  it.exp[0], int'(it.stim));
        check("R3", cy,  it.exp[1], int'(it.stim));
        check("R4", cz,  it.exp[2], int'(it.stim));
        check("R5", ggn, it.exp[3], int'(it.stim));
        check("R6", gpn, it.exp[4], int'(it.stim));
      end else if (drive_done) begin
        mon_done = 1;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    gen_n = 4'hF; prop_n = 4'hF; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle state, nothing asserted -> no carries, group flags deasserted
    drive(9'h0FF);
    // R1: single asserted generate at slice 0, low bit = asserted
    drive(9'h0FE);
    // R7: ascending sweep
    for (int i = 0; i < 512; i++) drive(9'(i));
    // R7: descending sweep, different predecessor per combination
    for (int i = 511; i >= 0; i--) drive(9'(i));
    // R5: group generate unchanged when only carry_i toggles
    for (int i = 0; i < 256; i++) begin
      drive(9'(i));
      drive(9'(i) | 9'h100);
    end
    drive_done = 1;
  end

  initial begin
    int cyc = 0;
    while (!mon_done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!mon_done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule